// File: doc/BRIEF.md
# Stereo Serial Audio Output Formatter

This block takes one pair of 20-bit two's-complement samples per audio frame and shifts them out, most significant bit first, on a single serial data line. It is a slave: the bit clock and the frame clock come from outside. Both clocks are oversampled by the block's system clock, and every output change is aligned to a detected falling edge of the bit clock, so a receiver can capture on the rising edge.

A single format input chooses between two layouts. Format 0 is MSB-justified with 16 bits per channel. The frame clock is high for the left channel, and the first data bit occupies the slot that starts at the frame-clock transition. Format 1 is I2S-compatible with 20 bits per channel. The frame clock is low for the left channel, and the first data bit appears one bit clock after the transition. Both samples are captured together when the left half-frame starts, so the right word always belongs to the same pair as the left one.

After reset is released, the block sends two's-complement zero for a programmable number of frames (4128 by default), and then starts sending real samples. While reset is held low, the data line is driven low.

Top module: `audfmt_tx`

## Requirements
- R1: While `rst_n` is low, `sdo_o` is 0, whatever the clocks and sample inputs do.
- R2: `sdo_o` changes only in response to a falling edge of `bclk_i`, and it stays constant through the whole high phase of the bit clock.
- R3: With `fmt_i` = 0, `lrck_i` = 1 marks the left channel and `lrck_i` = 0 marks the right. In slot k of a half-frame (slot 0 starts at the `lrck_i` transition), bit 19-k of the sample is sent for k = 0..15. The sample's bits 3..0 are never sent.
- R4: With `fmt_i` = 1, `lrck_i` = 0 marks the left channel and `lrck_i` = 1 marks the right. In slot k of a half-frame, bit 20-k of the sample is sent for k = 1..20.
- R5: Any slot of a half-frame that carries no data bit under R3, R4 or R8 is driven 0.
- R6: Both `left_i` and `right_i` are captured when a left half-frame starts. The right half-frame sends the captured right value, even if `right_i` changes during the left half.
- R7: The first MUTE_FRAMES frames that start after reset is released carry zero in both channels. The frame after them carries the live samples.
- R8: With `fmt_i` = 1 and exactly 20 slots per half-frame, bit 0 of the previous half-frame's word is sent in slot 0 of the next half-frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial clocks |
| rst_n | input | 1 | Active-low reset; low holds the output low and restarts the zero period |
| bclk_i | input | 1 | External bit clock |
| lrck_i | input | 1 | External frame (channel-select) clock |
| fmt_i | input | 1 | 0: 16-bit MSB-justified, left on high; 1: 20-bit I2S, left on low |
| left_i | input | 20 | Left sample, two's complement |
| right_i | input | 20 | Right sample, two's complement |
| sdo_o | output | 1 | Serial data output |

## Verification
The bench builds the block with MUTE_FRAMES = 3, so a full run crosses the boundary between zero output and live output after a reset, and repeats that for every format. The other parameters keep their defaults, so the 20-bit word, the 16-bit truncation and the two-stage synchronizer are the ones that ship. Each format runs at 32 slots per half-frame. Format 0 also runs at exactly 16 slots per half-frame, and format 1 at exactly 20, which covers the case where the last I2S bit spills into the next half-frame. Random samples are mixed with directed extremes and with samples whose only set bits are the low bits that 16-bit mode drops.

// File: rtl/audfmt_pkg.sv
package audfmt_pkg;

    // Format select encoding
    localparam logic FMT_MSBJ16 = 1'b0;
    localparam logic FMT_I2S20  = 1'b1;

    // Level of the frame clock that marks the left channel
    function automatic logic left_level(input logic fmt);
        return (fmt == FMT_MSBJ16) ? 1'b1 : 1'b0;
    endfunction

    // Edge detector state
    typedef struct packed {
        logic bclk;
        logic lr;
        logic primed;
    } edge_st_t;

endpackage

// File: rtl/audfmt_sync.sv
module audfmt_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        logic [WIDTH-1:0] stage_d;
        if (g == 0) begin : g_first
            assign stage_d = d_i;
        end else begin : g_next
            assign stage_d = stage_q[g-1];
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[g] <= '0;
            else        stage_q[g] <= stage_d;
        end
    end

    assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/audfmt_edge.sv
module audfmt_edge
    import audfmt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic bclk_s_i,
    input  logic lrck_s_i,
    input  logic fmt_i,
    output logic fall_o,
    output logic chan_start_o,
    output logic left_start_o
);

    edge_st_t st_d, st_q;
    logic     fall;

    always_comb begin
        st_d      = st_q;
        fall      = st_q.bclk & ~bclk_s_i;
        st_d.bclk = bclk_s_i;
        if (fall) begin
            st_d.primed = 1'b1;
            st_d.lr     = lrck_s_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // A channel starts at the first falling edge that sees the new frame level
    assign fall_o       = fall;
    assign chan_start_o = fall & st_q.primed & (lrck_s_i != st_q.lr);
    assign left_start_o = chan_start_o & (lrck_s_i == left_level(fmt_i));

endmodule

// File: rtl/audfmt_mute.sv
module audfmt_mute #(
    parameter int MUTE_FRAMES = 4128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic left_start_i,
    output logic muting_o
);

    localparam int CW = $clog2(MUTE_FRAMES + 1);
    localparam logic [CW-1:0] LIMIT = CW'(MUTE_FRAMES);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } mute_st_t;

    mute_st_t st_d, st_q;

    assign muting_o = (st_q.cnt < LIMIT);

    always_comb begin
        st_d = st_q;
        if (left_start_i && muting_o) st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_MUTE_ENDS_AT_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(muting_o) |-> $past(left_start_i)); // R7

endmodule

// File: rtl/audfmt_shift.sv
module audfmt_shift
    import audfmt_pkg::*;
#(
    parameter int W       = 20,
    parameter int SHORT_W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         fall_i,
    input  logic         chan_start_i,
    input  logic         fmt_i,
    input  logic [W-1:0] word_i,
    output logic         sdo_o
);

    localparam int PAD = W - SHORT_W;
    localparam logic [W-1:0] KEEP_MASK = ~(W'((64'd1 << PAD) - 64'd1));

    typedef struct packed {
        logic [W-1:0] sh;
        logic         sdo;
    } shift_st_t;

    shift_st_t    st_d, st_q;
    logic [W-1:0] aligned;

    // Short format keeps only the upper SHORT_W bits
    assign aligned = (fmt_i == FMT_I2S20) ? word_i : (word_i & KEEP_MASK);

    always_comb begin
        st_d = st_q;
        if (fall_i) begin
            if (chan_start_i && fmt_i == FMT_MSBJ16) begin
                st_d.sdo = aligned[W-1];
                st_d.sh  = aligned << 1;
            end else if (chan_start_i) begin
                // I2S: this slot still carries the tail of the previous word
                st_d.sdo = st_q.sh[W-1];
                st_d.sh  = aligned;
            end else begin
                st_d.sdo = st_q.sh[W-1];
                st_d.sh  = st_q.sh << 1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sdo_o = st_q.sdo;

    AST_HOLD_BETWEEN_FALLS: assert property (@(posedge clk) disable iff (!rst_n)
        !fall_i |=> $stable(sdo_o)); // R2
    AST_MSBJ_FIRST_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        fall_i && chan_start_i && fmt_i == FMT_MSBJ16 |=> sdo_o == $past(word_i[W-1])); // R3
    AST_I2S_LOADS_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        fall_i && chan_start_i && fmt_i == FMT_I2S20 |=> st_q.sh == $past(word_i)); // R4
    AST_TRAIL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        fall_i && !chan_start_i && st_q.sh == '0 |=> !sdo_o); // R5

endmodule

// File: rtl/audfmt_tx.sv
module audfmt_tx
    import audfmt_pkg::*;
#(
    parameter int SAMPLE_W    = 20,
    parameter int SHORT_W     = 16,
    parameter int MUTE_FRAMES = 4128,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bclk_i,
    input  logic                lrck_i,
    input  logic                fmt_i,
    input  logic [SAMPLE_W-1:0] left_i,
    input  logic [SAMPLE_W-1:0] right_i,
    output logic                sdo_o
);

    typedef struct packed {
        logic [SAMPLE_W-1:0] l;
        logic [SAMPLE_W-1:0] r;
    } hold_st_t;

    logic [1:0]          clk_s;
    logic                fall, chan_start, left_start, muting;
    logic [SAMPLE_W-1:0] load_word;
    hold_st_t            hold_d, hold_q;

    audfmt_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({bclk_i, lrck_i}),
        .q_o   (clk_s)
    );

    audfmt_edge edge_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .bclk_s_i     (clk_s[1]),
        .lrck_s_i     (clk_s[0]),
        .fmt_i        (fmt_i),
        .fall_o       (fall),
        .chan_start_o (chan_start),
        .left_start_o (left_start)
    );

    audfmt_mute #(.MUTE_FRAMES(MUTE_FRAMES)) mute_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .left_start_i (left_start),
        .muting_o     (muting)
    );

    always_comb begin
        hold_d    = hold_q;
        load_word = hold_q.r;
        if (left_start) begin
            if (muting) begin
                hold_d    = '0;
                load_word = '0;
            end else begin
                hold_d.l  = left_i;
                hold_d.r  = right_i;
                load_word = left_i;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hold_q <= '0;
        else        hold_q <= hold_d;
    end

    audfmt_shift #(.W(SAMPLE_W), .SHORT_W(SHORT_W)) shift_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .fall_i       (fall),
        .chan_start_i (chan_start),
        .fmt_i        (fmt_i),
        .word_i       (load_word),
        .sdo_o        (sdo_o)
    );

    AST_PAIR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !left_start |=> $stable(hold_q)); // R6
    AST_MUTE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        left_start && muting |=> hold_q == '0); // R7
    AST_RIGHT_FROM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        chan_start && !left_start |-> load_word == hold_q.r); // R6

endmodule

// File: tb/audfmt_tx_tb_top.sv
module audfmt_tx_tb_top;

    localparam int H    = 6;   // clk cycles per bit-clock phase
    localparam int MUTE = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bclk = 1'b1;
    logic        lrck = 1'b0;
    logic        fmt = 1'b0;
    logic [19:0] left_s = '0;
    logic [19:0] right_s = '0;
    logic        sdo;

    int checks = 0;
    int errors = 0;
    int sidx = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    audfmt_tx #(.MUTE_FRAMES(MUTE)) dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .bclk_i  (bclk),
        .lrck_i  (lrck),
        .fmt_i   (fmt),
        .left_i  (left_s),
        .right_i (right_s),
        .sdo_o   (sdo)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // One bit slot: falling edge, hold low, sample, rising edge, hold high, sample again
    task automatic slot(input logic lr, output logic b_rise, output logic b_end);
        @(negedge clk);
        bclk = 1'b0;
        lrck = lr;
        repeat (H) @(negedge clk);
        b_rise = sdo;
        bclk = 1'b1;
        repeat (H - 1) @(negedge clk);
        b_end = sdo;
    endtask

    // Expected serial bits of one half-frame, slot k at bit k
    function automatic logic [31:0] exp_half(input logic f, input int n,
                                             input logic [19:0] w, input logic [19:0] prevw);
        logic [31:0] e = '0;
        for (int k = 0; k < n; k++) begin
            if (f == 1'b0) begin
                if (k < 16) e[k] = w[19-k];
            end else begin
                if (k == 0 && n == 20) e[k] = prevw[0];
                else if (k >= 1 && k <= 20) e[k] = w[20-k];
            end
        end
        return e;
    endfunction

    function automatic logic [31:0] trail_mask(input logic f, input int n);
        logic [31:0] m = '0;
        for (int k = 0; k < n; k++) begin
            if (f == 1'b0) m[k] = (k >= 16);
            else m[k] = (k > 20) || (k == 0 && n != 20);
        end
        return m;
    endfunction

    function automatic logic [19:0] pick(input int idx);
        case (idx)
            0: return 20'h80000;
            1: return 20'h7FFFF;
            2: return 20'h0000F;
            3: return 20'hFFFFF;
            4: return 20'h00001;
            default: return 20'($urandom());
        endcase
    endfunction

    task automatic half(input logic f, input int n, input logic lvl, input bit change,
                        input logic [19:0] w, input logic [19:0] prevw, input string tag);
        logic [31:0] act = '0;
        int unstable = 0;
        logic br, be;
        for (int k = 0; k < n; k++) begin
            slot(lvl, br, be);
            act[k] = br;
            if (br !== be) unstable++;
            if (change && k == n / 2) begin
                left_s  = pick(sidx);
                right_s = pick(sidx + 1);
                sidx += 2;
            end
        end
        check(tag, act, exp_half(f, n, w, prevw));
        check("R5 trailing slots low", act & trail_mask(f, n), 32'h0);
        check("R2 stable through high phase", unstable, 0);
    endtask

    task automatic run(input logic f, input int n, input int nframes);
        logic br, be;
        logic lvl;
        logic [19:0] cur_l, cur_r, wl, wr, prevw;
        string tag;
        fmt = f;
        rst_n = 1'b0;
        left_s = 20'hABCDE;
        right_s = 20'h54321;
        for (int k = 0; k < 6; k++) begin
            slot(k[1], br, be);
            check("R1 output low in reset", {31'h0, br}, 32'h0);
        end
        @(negedge clk);
        rst_n = 1'b1;
        lvl = (f == 1'b0);
        for (int k = 0; k < 2; k++) slot(~lvl, br, be);
        left_s  = pick(sidx);
        right_s = pick(sidx + 1);
        sidx += 2;
        prevw = '0;
        for (int fr = 1; fr <= nframes; fr++) begin
            cur_l = left_s;
            cur_r = right_s;
            wl = (fr <= MUTE) ? 20'h0 : cur_l;
            wr = (fr <= MUTE) ? 20'h0 : cur_r;
            if (fr <= MUTE + 1) tag = "R7 zero period";
            else if (f == 1'b0) tag = "R3 msb-justified left";
            else if (n == 20) tag = "R8 i2s 40fs left";
            else tag = "R4 i2s left";
            half(f, n, lvl, 1'b1, wl, prevw, tag);
            prevw = wl;
            if (fr <= MUTE + 1) tag = "R7 zero period right";
            else if (n == 20) tag = "R8 R6 i2s 40fs right";
            else tag = "R6 captured right word";
            half(f, n, ~lvl, 1'b0, wr, prevw, tag);
            prevw = wr;
        end
    endtask

    initial begin
        void'($urandom(32'd20417));
        repeat (3) @(negedge clk);
        check("R1 reset state", {31'h0, sdo}, 32'h0);
        run(1'b0, 32, 10);
        run(1'b0, 16, 8);
        run(1'b1, 32, 10);
        run(1'b1, 20, 8);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule